// File: doc/BRIEF.md
# Serial Divider-Setting Port

This block is the configuration front end of a dual frequency synthesizer. A host writes 23-bit words over three wires: a data line, a serial clock and a load strobe. The block samples all three with the system clock. While the strobe is low, each rising serial-clock edge shifts one bit into a 23-bit register, most significant bit first. A rising edge on the strobe then copies the register into one of four holding latches. The two bits shifted in last choose the latch. Two latches hold a reference divide ratio and a charge-pump current bit, one for the low-frequency loop and one for the high-frequency loop. The other two latches hold the swallow count, the main count, a prescaler modulus bit and a detector polarity bit for each loop.

A word with a divide ratio below the legal floor is refused, and an error flag is raised instead. The latched settings leave the block as plain outputs for the dividers, which sit outside this block. The block also drives one shared monitor pin. In monitor mode the pin carries one of four internal reference or comparison pulse trains. In lock mode it carries the combined lock indication of both loops.

Top module: `synth_cfg_port`

## Requirements
- R1: Serial bits enter the register one per synchronised rising edge of `ser_clk`, most significant bit first, so the last bit shifted lands at bit 0. A full word takes 23 edges.
- R2: Serial-clock edges seen while `ser_le` is high leave the shift register unchanged.
- R3: A synchronised rising edge of `ser_le` causes exactly one load, however long the strobe stays high. The destination code is {bit1, bit0}: 00 is the low-loop reference latch, 01 the high-loop reference latch, 10 the low-loop counter latch and 11 the high-loop counter latch.
- R4: Reference word layout:
  - bits 3:2 form the monitor select code;
  - bits 17:4 hold the reference ratio;
  - bit 18 is the charge-pump current select (1 means high current);
  - bits 22:19 are ignored.
- R5: Counter word layout:
  - bit 2 is the monitor-mode bit (1 means pulse monitor);
  - bit 3 is the modulus select;
  - bit 4 is the polarity bit;
  - bits 11:5 hold the swallow count;
  - bits 22:12 hold the main count.
- R6: A load changes only the latch it addresses. The monitor select code follows the latest accepted reference word, and the monitor-mode bit follows the latest accepted counter word.
- R7: A reference word whose ratio is below 3, or a counter word whose main count is below 3, changes no latch and sets `cfg_err`. The next accepted load clears `cfg_err`.
- R8: With monitor mode set, `mon_out` follows the input picked by the select code, one system clock later. Code 0 picks `fr_if`, 1 picks `fr_rf`, 2 picks `fp_if` and 3 picks `fp_rf`.
- R9: With monitor mode clear, `mon_out` is `lock_if AND lock_rf`, one system clock later.
- R10: After reset, both ratios and both main counts read 3. The swallow counts, all single-bit settings, the select code, `cfg_err` and `mon_out` read 0.
- R11: When the serial clock and the strobe rise in the same synchronised cycle, the load uses the register as it was before that edge, and the bit present on the data line is not shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_le | input | 1 | Load strobe (asynchronous) |
| fr_if | input | 1 | Low-loop reference pulse |
| fr_rf | input | 1 | High-loop reference pulse |
| fp_if | input | 1 | Low-loop comparison pulse |
| fp_rf | input | 1 | High-loop comparison pulse |
| lock_if | input | 1 | Low-loop locked or idle |
| lock_rf | input | 1 | High-loop locked or idle |
| if_ref_ratio | output | 14 | Low-loop reference ratio |
| if_cp_hi | output | 1 | Low-loop high charge-pump current |
| rf_ref_ratio | output | 14 | High-loop reference ratio |
| rf_cp_hi | output | 1 | High-loop high charge-pump current |
| if_swallow | output | 7 | Low-loop swallow count |
| if_main | output | 11 | Low-loop main count |
| if_mod_sel | output | 1 | Low-loop modulus select |
| if_polarity | output | 1 | Low-loop detector polarity |
| rf_swallow | output | 7 | High-loop swallow count |
| rf_main | output | 11 | High-loop main count |
| rf_mod_sel | output | 1 | High-loop modulus select |
| rf_polarity | output | 1 | High-loop detector polarity |
| test_sel | output | 2 | Monitor select code |
| mon_mode | output | 1 | 1 selects pulse monitor, 0 selects lock |
| mon_out | output | 1 | Shared monitor/lock pin |
| cfg_err | output | 1 | Last load refused for an illegal ratio |

## Verification
The shift and the load can fall in the same synchronised cycle. This happens when the host raises the serial clock and the load strobe together. The bench provokes the collision by shifting a complete reference word and then, with a 1 on the data line, raising both lines in the same time step. The bench judges the result at the outputs: the addressed latch must hold the un-shifted word's ratio. A shifted word would carry a different destination code, so it would have changed a different latch.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    // Frame geometry
    localparam int WORD_W   = 23;
    localparam int NUM_CH   = 2;
    localparam int CHAN_BIT = 0;              // 0: low loop, 1: high loop
    localparam int KIND_BIT = 1;              // 0: reference word, 1: counter word

    // Reference word fields
    localparam int TSEL_W   = 2;
    localparam int TSEL_LSB = 2;
    localparam int RATIO_W  = 14;
    localparam int R_LSB    = TSEL_LSB + TSEL_W;
    localparam int CP_BIT   = R_LSB + RATIO_W;

    // Counter word fields
    localparam int LDS_BIT  = 2;
    localparam int MOD_BIT  = LDS_BIT + 1;
    localparam int POL_BIT  = MOD_BIT + 1;
    localparam int SWL_W    = 7;
    localparam int SWL_LSB  = POL_BIT + 1;
    localparam int MAIN_W   = 11;
    localparam int MAIN_LSB = SWL_LSB + SWL_W;

    typedef enum logic [1:0] {
        SRC_FR_IF = 2'd0,
        SRC_FR_RF = 2'd1,
        SRC_FP_IF = 2'd2,
        SRC_FP_RF = 2'd3
    } mon_src_e;

    typedef struct packed {
        logic [TSEL_W-1:0]  tsel;
        logic [RATIO_W-1:0] ratio;
        logic               cp_hi;
    } ref_word_t;

    typedef struct packed {
        logic               lds;
        logic               mod_sel;
        logic               pol;
        logic [SWL_W-1:0]   swl;
        logic [MAIN_W-1:0]  main;
    } cnt_word_t;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               cp_hi;
    } ref_latch_t;

    typedef struct packed {
        logic               mod_sel;
        logic               pol;
        logic [SWL_W-1:0]   swl;
        logic [MAIN_W-1:0]  main;
    } cnt_latch_t;

    function automatic ref_word_t unpack_ref(input logic [WORD_W-1:0] w);
        ref_word_t r;
        r.tsel  = w[TSEL_LSB +: TSEL_W];
        r.ratio = w[R_LSB +: RATIO_W];
        r.cp_hi = w[CP_BIT];
        return r;
    endfunction

    function automatic cnt_word_t unpack_cnt(input logic [WORD_W-1:0] w);
        cnt_word_t c;
        c.lds     = w[LDS_BIT];
        c.mod_sel = w[MOD_BIT];
        c.pol     = w[POL_BIT];
        c.swl     = w[SWL_LSB +: SWL_W];
        c.main    = w[MAIN_LSB +: MAIN_W];
        return c;
    endfunction

endpackage

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_le,
    output logic [WORD_W-1:0] word,
    output logic              shift_stb,
    output logic              load_stb,
    output logic              le_lvl
);

    localparam int LINES = 3;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] stage_q [SYNC_STAGES];
    logic [LINES-1:0] synced;
    logic             sclk_d;
    logic             le_d;
    logic             sclk_rise;

    assign raw = {ser_le, ser_clk, ser_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < SYNC_STAGES; k++) begin
                stage_q[k] <= '0;
            end
        end else begin
            stage_q[0] <= raw;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign synced = stage_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            le_d   <= 1'b0;
        end else begin
            sclk_d <= synced[1];
            le_d   <= synced[2];
        end
    end

    assign sclk_rise = synced[1] & ~sclk_d;
    assign le_lvl    = synced[2];
    assign shift_stb = sclk_rise & ~synced[2];
    assign load_stb  = synced[2] & ~le_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (shift_stb) begin
            word <= {word[WORD_W-2:0], synced[0]};
        end
    end

endmodule

// File: rtl/synth_cfg_latches.sv
module synth_cfg_latches
    import synth_cfg_pkg::*;
#(
    parameter int MIN_DIV = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_stb,
    input  logic [WORD_W-1:0] word,
    output ref_latch_t        ref_q [NUM_CH],
    output cnt_latch_t        cnt_q [NUM_CH],
    output logic [TSEL_W-1:0] tsel_q,
    output logic              lds_q,
    output logic              err_q
);

    localparam logic [RATIO_W-1:0] R_MIN = RATIO_W'(MIN_DIV);
    localparam logic [MAIN_W-1:0]  N_MIN = MAIN_W'(MIN_DIV);

    ref_word_t rw;
    cnt_word_t cw;
    logic      is_cnt;
    logic      ch_sel;
    logic      ref_ok;
    logic      cnt_ok;
    logic      any_bad;

    assign rw      = unpack_ref(word);
    assign cw      = unpack_cnt(word);
    assign is_cnt  = word[KIND_BIT];
    assign ch_sel  = word[CHAN_BIT];
    assign ref_ok  = load_stb & ~is_cnt & (rw.ratio >= R_MIN);
    assign cnt_ok  = load_stb &  is_cnt & (cw.main  >= N_MIN);
    assign any_bad = load_stb & ~ref_ok & ~cnt_ok;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                ref_q[g] <= '{ratio: R_MIN, cp_hi: 1'b0};
            end else if (ref_ok && ch_sel == 1'(g)) begin
                ref_q[g] <= '{ratio: rw.ratio, cp_hi: rw.cp_hi};
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[g] <= '{mod_sel: 1'b0, pol: 1'b0, swl: '0, main: N_MIN};
            end else if (cnt_ok && ch_sel == 1'(g)) begin
                cnt_q[g] <= '{mod_sel: cw.mod_sel, pol: cw.pol, swl: cw.swl, main: cw.main};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tsel_q <= '0;
            lds_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (ref_ok) begin
                tsel_q <= rw.tsel;
            end
            if (cnt_ok) begin
                lds_q <= cw.lds;
            end
            if (any_bad) begin
                err_q <= 1'b1;
            end else if (ref_ok || cnt_ok) begin
                err_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/synth_cfg_monitor.sv
module synth_cfg_monitor
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TSEL_W-1:0] tsel,
    input  logic              lds,
    input  logic              fr_if,
    input  logic              fr_rf,
    input  logic              fp_if,
    input  logic              fp_rf,
    input  logic              lock_if,
    input  logic              lock_rf,
    output logic              mon_out
);

    mon_src_e src;
    logic     tap;
    logic     mon_d;

    assign src = mon_src_e'(tsel);

    always_comb begin
        unique case (src)
            SRC_FR_IF: tap = fr_if;
            SRC_FR_RF: tap = fr_rf;
            SRC_FP_IF: tap = fp_if;
            SRC_FP_RF: tap = fp_rf;
            default:   tap = 1'b0;
        endcase
    end

    assign mon_d = lds ? tap : (lock_if & lock_rf);

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_out <= 1'b0;
        end else begin
            mon_out <= mon_d;
        end
    end

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_DIV     = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_data,
    input  logic               ser_clk,
    input  logic               ser_le,
    input  logic               fr_if,
    input  logic               fr_rf,
    input  logic               fp_if,
    input  logic               fp_rf,
    input  logic               lock_if,
    input  logic               lock_rf,
    output logic [RATIO_W-1:0] if_ref_ratio,
    output logic               if_cp_hi,
    output logic [RATIO_W-1:0] rf_ref_ratio,
    output logic               rf_cp_hi,
    output logic [SWL_W-1:0]   if_swallow,
    output logic [MAIN_W-1:0]  if_main,
    output logic               if_mod_sel,
    output logic               if_polarity,
    output logic [SWL_W-1:0]   rf_swallow,
    output logic [MAIN_W-1:0]  rf_main,
    output logic               rf_mod_sel,
    output logic               rf_polarity,
    output logic [TSEL_W-1:0]  test_sel,
    output logic               mon_mode,
    output logic               mon_out,
    output logic               cfg_err
);

    logic [WORD_W-1:0] sh_word;
    logic              shift_stb;
    logic              load_stb;
    logic              le_lvl;
    ref_latch_t        ref_q [NUM_CH];
    cnt_latch_t        cnt_q [NUM_CH];

    synth_cfg_shift #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .ser_data  (ser_data),
        .ser_clk   (ser_clk),
        .ser_le    (ser_le),
        .word      (sh_word),
        .shift_stb (shift_stb),
        .load_stb  (load_stb),
        .le_lvl    (le_lvl)
    );

    synth_cfg_latches #(
        .MIN_DIV (MIN_DIV)
    ) u_latches (
        .clk      (clk),
        .rst      (rst),
        .load_stb (load_stb),
        .word     (sh_word),
        .ref_q    (ref_q),
        .cnt_q    (cnt_q),
        .tsel_q   (test_sel),
        .lds_q    (mon_mode),
        .err_q    (cfg_err)
    );

    synth_cfg_monitor u_monitor (
        .clk     (clk),
        .rst     (rst),
        .tsel    (test_sel),
        .lds     (mon_mode),
        .fr_if   (fr_if),
        .fr_rf   (fr_rf),
        .fp_if   (fp_if),
        .fp_rf   (fp_rf),
        .lock_if (lock_if),
        .lock_rf (lock_rf),
        .mon_out (mon_out)
    );

    assign if_ref_ratio = ref_q[0].ratio;
    assign if_cp_hi     = ref_q[0].cp_hi;
    assign rf_ref_ratio = ref_q[1].ratio;
    assign rf_cp_hi     = ref_q[1].cp_hi;
    assign if_swallow   = cnt_q[0].swl;
    assign if_main      = cnt_q[0].main;
    assign if_mod_sel   = cnt_q[0].mod_sel;
    assign if_polarity  = cnt_q[0].pol;
    assign rf_swallow   = cnt_q[1].swl;
    assign rf_main      = cnt_q[1].main;
    assign rf_mod_sel   = cnt_q[1].mod_sel;
    assign rf_polarity  = cnt_q[1].pol;

endmodule

// File: rtl/synth_cfg_port_chk.sv
module synth_cfg_port_chk
    import synth_cfg_pkg::*;
#(
    parameter int MIN_DIV = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               shift_stb,
    input logic               load_stb,
    input logic               le_lvl,
    input logic [WORD_W-1:0]  sh_word,
    input logic [RATIO_W-1:0] if_ref_ratio,
    input logic [RATIO_W-1:0] rf_ref_ratio,
    input logic [MAIN_W-1:0]  if_main,
    input logic [MAIN_W-1:0]  rf_main,
    input logic               cfg_err,
    input logic               mon_mode,
    input logic               lock_if,
    input logic               lock_rf,
    input logic               mon_out
);

    localparam logic [RATIO_W-1:0] R_MIN = RATIO_W'(MIN_DIV);
    localparam logic [MAIN_W-1:0]  N_MIN = MAIN_W'(MIN_DIV);

    // R2: word frozen while the strobe is high
    p_le_freezes_r2: assert property (@(posedge clk) disable iff (rst)
        le_lvl |=> $stable(sh_word));

    // R3: one load per strobe edge
    p_single_load_r3: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> !load_stb);

    // R3: no shift in the load cycle
    p_load_no_shift_r11: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> !shift_stb);

    // R5: accepted high-loop counter word reaches the main count
    p_rf_main_load_r5: assert property (@(posedge clk) disable iff (rst)
        (load_stb && sh_word[1:0] == 2'b11 && sh_word[MAIN_LSB +: MAIN_W] >= N_MIN)
        |=> rf_main == $past(sh_word[MAIN_LSB +: MAIN_W]));

    // R6: low-loop reference load touches no other ratio
    p_route_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (load_stb && sh_word[1:0] == 2'b00)
        |=> ($stable(rf_ref_ratio) && $stable(if_main) && $stable(rf_main)));

    // R7: illegal reference ratio refused and flagged
    p_reject_r7: assert property (@(posedge clk) disable iff (rst)
        (load_stb && !sh_word[KIND_BIT] && sh_word[R_LSB +: RATIO_W] < R_MIN)
        |=> (cfg_err && $stable(if_ref_ratio) && $stable(rf_ref_ratio)));

    // R7: latched ratios never drop under the floor
    p_floor_r7: assert property (@(posedge clk) disable iff (rst)
        (if_ref_ratio >= R_MIN) && (rf_ref_ratio >= R_MIN) &&
        (if_main >= N_MIN) && (rf_main >= N_MIN));

    // R9: unlock on either loop pulls the pin low in lock mode
    p_lock_low_r9: assert property (@(posedge clk) disable iff (rst)
        (!mon_mode && !(lock_if && lock_rf)) |=> !mon_out);

endmodule

bind synth_cfg_port synth_cfg_port_chk #(.MIN_DIV(MIN_DIV)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .shift_stb    (shift_stb),
    .load_stb     (load_stb),
    .le_lvl       (le_lvl),
    .sh_word      (sh_word),
    .if_ref_ratio (if_ref_ratio),
    .rf_ref_ratio (rf_ref_ratio),
    .if_main      (if_main),
    .rf_main      (rf_main),
    .cfg_err      (cfg_err),
    .mon_mode     (mon_mode),
    .lock_if      (lock_if),
    .lock_rf      (lock_rf),
    .mon_out      (mon_out)
);

// File: tb/test_synth_cfg_port.sv
module test_synth_cfg_port;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_le = 1'b0;
    logic fr_if = 1'b0, fr_rf = 1'b0, fp_if = 1'b0, fp_rf = 1'b0;
    logic lock_if = 1'b0, lock_rf = 1'b0;
    logic [13:0] if_ref_ratio, rf_ref_ratio;
    logic        if_cp_hi, rf_cp_hi;
    logic [6:0]  if_swallow, rf_swallow;
    logic [10:0] if_main, rf_main;
    logic        if_mod_sel, if_polarity, rf_mod_sel, rf_polarity;
    logic [1:0]  test_sel;
    logic        mon_mode, mon_out, cfg_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model of the latches
    int e_ratio [2];
    int e_cp    [2];
    int e_swl   [2];
    int e_main  [2];
    int e_mod   [2];
    int e_pol   [2];
    int e_tsel, e_lds, e_err;

    always #10 clk = ~clk;

    synth_cfg_port i_synth_cfg_port (
        .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le),
        .fr_if(fr_if), .fr_rf(fr_rf), .fp_if(fp_if), .fp_rf(fp_rf),
        .lock_if(lock_if), .lock_rf(lock_rf),
        .if_ref_ratio(if_ref_ratio), .if_cp_hi(if_cp_hi),
        .rf_ref_ratio(rf_ref_ratio), .rf_cp_hi(rf_cp_hi),
        .if_swallow(if_swallow), .if_main(if_main),
        .if_mod_sel(if_mod_sel), .if_polarity(if_polarity),
        .rf_swallow(rf_swallow), .rf_main(rf_main),
        .rf_mod_sel(rf_mod_sel), .rf_polarity(rf_polarity),
        .test_sel(test_sel), .mon_mode(mon_mode), .mon_out(mon_out), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [22:0] ref_word(input int ch, input int t, input int r,
                                             input int cp, input int junk);
        return {4'(junk), 1'(cp), 14'(r), 2'(t), 1'b0, 1'(ch)};
    endfunction

    function automatic logic [22:0] cnt_word(input int ch, input int lds, input int md,
                                             input int pol, input int a, input int n);
        return {11'(n), 7'(a), 1'(pol), 1'(md), 1'(lds), 1'b1, 1'(ch)};
    endfunction

    task automatic shift_bits(input logic [22:0] w);
        for (int i = 22; i >= 0; i--) begin
            ser_data = w[i];
            tick(2);
            ser_clk = 1'b1;
            tick(3);
            ser_clk = 1'b0;
            tick(2);
        end
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        tick(6);
        ser_le = 1'b0;
        tick(4);
    endtask

    // expected effect of a load, taken from R3..R7
    task automatic model_load(input logic [22:0] w);
        int ch;
        ch = int'(w[0]);
        if (!w[1]) begin
            if (int'(w[17:4]) < 3) e_err = 1;
            else begin
                e_err = 0;
                e_ratio[ch] = int'(w[17:4]);
                e_cp[ch] = int'(w[18]);
                e_tsel = int'(w[3:2]);
            end
        end else begin
            if (int'(w[22:12]) < 3) e_err = 1;
            else begin
                e_err = 0;
                e_main[ch] = int'(w[22:12]);
                e_swl[ch] = int'(w[11:5]);
                e_pol[ch] = int'(w[4]);
                e_mod[ch] = int'(w[3]);
                e_lds = int'(w[2]);
            end
        end
    endtask

    task automatic check_all(input string req);
        check(int'(if_ref_ratio) == e_ratio[0], req, int'(if_ref_ratio), e_ratio[0]);
        check(int'(rf_ref_ratio) == e_ratio[1], req, int'(rf_ref_ratio), e_ratio[1]);
        check(int'(if_cp_hi) == e_cp[0], req, int'(if_cp_hi), e_cp[0]);
        check(int'(rf_cp_hi) == e_cp[1], req, int'(rf_cp_hi), e_cp[1]);
        check(int'(if_main) == e_main[0], req, int'(if_main), e_main[0]);
        check(int'(rf_main) == e_main[1], req, int'(rf_main), e_main[1]);
        check(int'(if_swallow) == e_swl[0], req, int'(if_swallow), e_swl[0]);
        check(int'(rf_swallow) == e_swl[1], req, int'(rf_swallow), e_swl[1]);
        check(int'(if_mod_sel) == e_mod[0], req, int'(if_mod_sel), e_mod[0]);
        check(int'(rf_mod_sel) == e_mod[1], req, int'(rf_mod_sel), e_mod[1]);
        check(int'(if_polarity) == e_pol[0], req, int'(if_polarity), e_pol[0]);
        check(int'(rf_polarity) == e_pol[1], req, int'(rf_polarity), e_pol[1]);
        check(int'(test_sel) == e_tsel, req, int'(test_sel), e_tsel);
        check(int'(mon_mode) == e_lds, req, int'(mon_mode), e_lds);
        check(int'(cfg_err) == e_err, req, int'(cfg_err), e_err);
    endtask

    task automatic send(input logic [22:0] w, input string req);
        shift_bits(w);
        pulse_le();
        model_load(w);
        check_all(req);
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            e_ratio[c] = 3; e_cp[c] = 0; e_swl[c] = 0; e_main[c] = 3;
            e_mod[c] = 0; e_pol[c] = 0;
        end
        e_tsel = 0; e_lds = 0; e_err = 0;
        tick(5);
        rst = 1'b0;
        tick(3);

        // R10 reset state
        check_all("R10");
        check(mon_out == 1'b0, "R10 mon_out", int'(mon_out), 0);

        // R1 R3 R4 R6: reference words into both loops, varied fields
        for (int ch = 0; ch < 2; ch++) begin
            send(ref_word(ch, 1, 3, 1, 0), "R1 R3 R4 R6 ratio floor");
            send(ref_word(ch, 2, 16383, 0, 15), "R1 R4 R6 ratio max, ignored top bits");
            send(ref_word(ch, 3, 'h2AAA, 1, 5), "R1 R4 alternating ratio");
            send(ref_word(ch, 0, 1000 + ch, 0, 0), "R3 R6 mid ratio");
        end

        // R1 R3 R5 R6: counter words into both loops
        for (int ch = 0; ch < 2; ch++) begin
            send(cnt_word(ch, 0, 1, 0, 0, 3), "R1 R3 R5 R6 main floor");
            send(cnt_word(ch, 1, 0, 1, 127, 2047), "R1 R5 R6 max counts");
            send(cnt_word(ch, 0, 1, 1, 'h2A, 'h555), "R5 alternating counts");
        end

        // R7: illegal ratios and main counts refused, then cleared
        for (int ch = 0; ch < 2; ch++) begin
            for (int v = 0; v < 3; v++) begin
                send(ref_word(ch, 3 - v, v, 1, 0), "R7 ref ratio below floor");
                send(cnt_word(ch, 1, 1, 1, 99, v), "R7 main count below floor");
            end
            send(ref_word(ch, 1, 77 + ch, 0, 0), "R7 accepted load clears error");
        end

        // R2: bits clocked while strobe high are ignored
        send(ref_word(0, 0, 100, 0, 0), "R2 setup");
        ser_le = 1'b1;
        tick(6);
        shift_bits(ref_word(1, 0, 200, 1, 0));
        ser_le = 1'b0;
        tick(4);
        pulse_le();
        model_load(ref_word(0, 0, 100, 0, 0));
        check_all("R2 shift under strobe ignored");

        // R11: serial clock edge and strobe edge in the same cycle
        shift_bits(ref_word(0, 2, 500, 1, 0));
        ser_data = 1'b1;
        tick(2);
        ser_clk = 1'b1;
        ser_le = 1'b1;
        tick(6);
        ser_clk = 1'b0;
        ser_le = 1'b0;
        tick(4);
        model_load(ref_word(0, 2, 500, 1, 0));
        check_all("R11 collision loads pre-edge word");

        // R8: monitor sweep over every code and input pattern
        send(cnt_word(0, 1, 0, 0, 5, 40), "R8 enter monitor mode");
        for (int t = 0; t < 4; t++) begin
            send(ref_word(1, t, 300 + t, 0, 0), "R8 select code");
            for (int p = 0; p < 16; p++) begin
                fr_if = p[0]; fr_rf = p[1]; fp_if = p[2]; fp_rf = p[3];
                tick(2);
                check(int'(mon_out) == int'(p[t]), "R8 monitor pick", int'(mon_out), int'(p[t]));
            end
        end
        fr_if = 1'b0; fr_rf = 1'b0; fp_if = 1'b0; fp_rf = 1'b0;

        // R9: lock mode, all lock combinations, monitor inputs held high
        send(cnt_word(1, 0, 0, 0, 9, 60), "R9 enter lock mode");
        fr_if = 1'b1; fr_rf = 1'b1; fp_if = 1'b1; fp_rf = 1'b1;
        for (int l = 0; l < 4; l++) begin
            lock_if = l[0];
            lock_rf = l[1];
            tick(2);
            check(int'(mon_out) == (l == 3 ? 1 : 0), "R9 lock combine",
                  int'(mon_out), (l == 3 ? 1 : 0));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule